// File: doc/BRIEF.md
# ECC Read-Modify-Write Scrubber

This block sits between a single-request host port and a 72-bit memory word port. Each 64-bit data word is stored with 8 check bits of an extended Hamming code. Full-word writes are encoded and stored in one memory write. Writes that enable only some of the bytes are turned into a read of the stored word, a merge of the new bytes and a write of the re-encoded full word.

Reads are decoded. A single-bit error is corrected in the returned data when correction is on. It can also be written back to the same location when scrubbing is on. Errors of two bits are flagged and never corrected. Configuration inputs turn ECC, correction and scrubbing on or off, and each request samples them when it is accepted.

Two capture slots hold the address and syndrome of the first correctable error and of the first uncorrectable error, each with a saturating event counter. A clear input resets the slots. The memory is a RAM with one cycle of read latency.

Top module: `ecc_rmw_scrubber`

## Requirements
- R1: With ECC on, a write with all 8 byte enables set makes exactly one memory write with all 9 lanes enabled (`mem_be_o` = 9'h1FF). A later read of that word returns the written data with `rsp_err_o`=0 and `rsp_ce_o`=0.
- R2: A stored ECC word holds data in bits [63:0], Hamming check bits in [70:64] and an overall parity bit in [71]. The parity bit makes the XOR of all 72 bits zero.
- R3: With ECC and correction on, a read of a word with any one flipped bit returns the original data with `rsp_ce_o`=1 and `rsp_err_o`=0.
- R4: With correction off, a single-bit error is still reported (`rsp_ce_o`=1), and the raw stored data bits are returned.
- R5: A word with two flipped bits reads back with `rsp_err_o`=1 and `rsp_ce_o`=0. It is logged as uncorrectable and causes no memory write.
- R6: With correction and scrubbing on, a correctable read error causes one write of the corrected codeword to the same address before the response. After it, the memory holds the original codeword.
- R7: With ECC on, a partial write reads the word, corrects a single-bit error in it and replaces only the enabled bytes (byte b = bits 8b+7:8b). It then writes the re-encoded full word, so that a later read shows no error.
- R8: With ECC on, a partial write to a word with an uncorrectable error makes no memory write, and it responds with `rsp_err_o`=1.
- R9: With ECC off, writes use lanes 0..7 from `req_be_i` and never lane 8 (check bits). Reads return the raw data with no error flags, even when the check bits are inconsistent.
- R10: A request with any address bit at or above bit 32 set makes no memory access, responds with `rsp_err_o`=1 and is not logged.
- R11: `req_ready_o` is high only when no request is in flight. Each accepted request gives exactly one single-cycle `rsp_valid_o` pulse, issued after any merge or scrub write.
- R12: The first correctable error and the first uncorrectable error each latch the byte address and the syndrome {overall parity mismatch, 7-bit Hamming position}. The latched values hold until `log_clr_i`. A flipped check bit 64+k gives the syndrome {1'b1, 7'(1<<k)}, and a flipped bit 71 gives 8'h80. The counters count every event, saturate, and are zeroed by `log_clr_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_ecc_en_i | input | 1 | Enable check-bit generation and checking |
| cfg_corr_en_i | input | 1 | Return corrected data on single-bit errors |
| cfg_scrub_en_i | input | 1 | Write corrected words back to memory |
| req_valid_i | input | 1 | Host request valid |
| req_ready_o | output | 1 | Block idle and able to accept a request |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | HOST_AW | Byte address |
| req_wdata_i | input | 64 | Write data |
| req_be_i | input | 8 | Byte enables for the write |
| rsp_valid_o | output | 1 | Single-cycle completion pulse |
| rsp_rdata_o | output | 64 | Read data |
| rsp_err_o | output | 1 | Uncorrectable error, aborted write or address out of range |
| rsp_ce_o | output | 1 | A correctable error was seen |
| mem_req_o | output | 1 | Memory access strobe |
| mem_we_o | output | 1 | Memory write |
| mem_addr_o | output | MEM_AW | Memory word address |
| mem_be_o | output | 9 | Lane enables; lane 8 covers the check bits |
| mem_wdata_o | output | 72 | Memory write word |
| mem_rdata_i | input | 72 | Memory read word, one cycle after the read strobe |
| log_clr_i | input | 1 | Clear both capture slots and their counters |
| ce_vld_o | output | 1 | Correctable-error slot holds a capture |
| ce_addr_o | output | 32 | Captured address of the correctable error |
| ce_syn_o | output | 8 | Captured syndrome of the correctable error |
| ce_cnt_o | output | CNT_W | Correctable-error count |
| ue_vld_o | output | 1 | Uncorrectable-error slot holds a capture |
| ue_addr_o | output | 32 | Captured address of the uncorrectable error |
| ue_syn_o | output | 8 | Captured syndrome of the uncorrectable error |
| ue_cnt_o | output | CNT_W | Uncorrectable-error count |

## Verification
The assertions check, on every cycle, the properties that can be seen on the memory strobes:
- every ECC write enables all nine lanes and has even overall parity;
- ECC-off writes never touch the check lane;
- out-of-range requests and aborted merges stay off the memory port;
- a held capture slot does not change;
- the counters never decrease;
- the host port returns to idle after each response.

Only the bench scenarios can show the following:
- that data is actually corrected;
- that a scrub restores the exact original codeword;
- that merged bytes land in the right lanes;
- that the captured syndromes match the injected bit positions.

// File: rtl/ecc_rmw_pkg.sv
package ecc_rmw_pkg;
  localparam int DW = 64;
  localparam int HW = 7;
  localparam int CW = 8;
  localparam int WW = DW + CW;
  localparam int NB = DW / 8;

  typedef enum logic [2:0] {
    ST_IDLE, ST_EXEC, ST_WAIT, ST_WB, ST_RESP
  } st_e;

  // Hamming check over positions 1..71; data fills the non-power-of-two slots.
  function automatic logic [HW-1:0] ham_bits(logic [DW-1:0] d);
    logic [HW-1:0] c;
    int j;
    c = '0;
    j = 0;
    for (int p = 1; p < WW; p++) begin
      if ((p & (p - 1)) != 0) begin
        if (d[j]) c = c ^ HW'(p);
        j++;
      end
    end
    return c;
  endfunction
endpackage

// File: rtl/ecc_enc.sv
module ecc_enc
  import ecc_rmw_pkg::*;
(
  input  logic [DW-1:0] data_i,
  output logic [WW-1:0] word_o
);
  logic [HW-1:0] chk;
  assign chk    = ham_bits(data_i);
  assign word_o = {^{chk, data_i}, chk, data_i};
endmodule

// File: rtl/ecc_dec.sv
module ecc_dec
  import ecc_rmw_pkg::*;
(
  input  logic [WW-1:0] word_i,
  output logic [DW-1:0] data_o,
  output logic [CW-1:0] syn_o,
  output logic          ce_o,
  output logic          ue_o
);
  logic [HW-1:0] syn_h;
  logic          par;

  assign syn_h = word_i[DW +: HW] ^ ham_bits(word_i[DW-1:0]);
  assign par   = ^word_i;
  assign syn_o = {par, syn_h};
  // odd parity with a position beyond the word is a multi-bit error
  assign ce_o  = par && (syn_h <= HW'(WW - 1));
  assign ue_o  = (!par && (syn_h != '0)) || (par && (syn_h > HW'(WW - 1)));

  always_comb begin
    int j;
    data_o = word_i[DW-1:0];
    j = 0;
    for (int p = 1; p < WW; p++) begin
      if ((p & (p - 1)) != 0) begin
        if (syn_h == HW'(p)) data_o[j] = ~data_o[j];
        j++;
      end
    end
  end
endmodule

// File: rtl/ecc_log_slot.sv
module ecc_log_slot #(
  parameter int AW    = 32,
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             ev_i,
  input  logic [AW-1:0]    addr_i,
  input  logic [7:0]       syn_i,
  output logic             vld_o,
  output logic [AW-1:0]    addr_o,
  output logic [7:0]       syn_o,
  output logic [CNT_W-1:0] cnt_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_o  <= 1'b0;
      addr_o <= '0;
      syn_o  <= '0;
      cnt_o  <= '0;
    end else if (clr_i) begin
      vld_o  <= 1'b0;
      addr_o <= '0;
      syn_o  <= '0;
      cnt_o  <= '0;
    end else if (ev_i) begin
      if (!vld_o) begin
        vld_o  <= 1'b1;
        addr_o <= addr_i;
        syn_o  <= syn_i;
      end
      if (cnt_o != '1) cnt_o <= cnt_o + 1'b1;
    end
  end

  a_r12_hold_first: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vld_o && !clr_i) |=> (vld_o && $stable(addr_o) && $stable(syn_o)));
  a_r12_cnt_mono: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_i |=> (cnt_o >= $past(cnt_o)));
endmodule

// File: rtl/ecc_rmw_scrubber.sv
module ecc_rmw_scrubber
  import ecc_rmw_pkg::*;
#(
  parameter int HOST_AW = 40,
  parameter int DEC_AW  = 32,
  parameter int MEM_AW  = 29,
  parameter int CNT_W   = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               cfg_ecc_en_i,
  input  logic               cfg_corr_en_i,
  input  logic               cfg_scrub_en_i,
  input  logic               req_valid_i,
  output logic               req_ready_o,
  input  logic               req_write_i,
  input  logic [HOST_AW-1:0] req_addr_i,
  input  logic [DW-1:0]      req_wdata_i,
  input  logic [NB-1:0]      req_be_i,
  output logic               rsp_valid_o,
  output logic [DW-1:0]      rsp_rdata_o,
  output logic               rsp_err_o,
  output logic               rsp_ce_o,
  output logic               mem_req_o,
  output logic               mem_we_o,
  output logic [MEM_AW-1:0]  mem_addr_o,
  output logic [NB:0]        mem_be_o,
  output logic [WW-1:0]      mem_wdata_o,
  input  logic [WW-1:0]      mem_rdata_i,
  input  logic               log_clr_i,
  output logic               ce_vld_o,
  output logic [DEC_AW-1:0]  ce_addr_o,
  output logic [CW-1:0]      ce_syn_o,
  output logic [CNT_W-1:0]   ce_cnt_o,
  output logic               ue_vld_o,
  output logic [DEC_AW-1:0]  ue_addr_o,
  output logic [CW-1:0]      ue_syn_o,
  output logic [CNT_W-1:0]   ue_cnt_o
);
  localparam int WORD_LSB = $clog2(NB);
  localparam int NSLOT    = 2;

  st_e               st_q, st_d;
  logic              wr_q, oor_q, ecc_q, corr_q, scrub_q;
  logic [DEC_AW-1:0] addr_q;
  logic [DW-1:0]     wdata_q, merge_q, rdata_q, merged;
  logic [NB-1:0]     be_q;
  logic              err_q, ce_q, oor_d, accept, full_be;
  logic [DW-1:0]     enc_in, dec_data;
  logic [WW-1:0]     enc_word;
  logic [CW-1:0]     dec_syn;
  logic              dec_ce, dec_ue, in_wait;

  generate
    if (HOST_AW > DEC_AW) begin : g_hi_dec
      assign oor_d = |req_addr_i[HOST_AW-1:DEC_AW];
    end else begin : g_no_hi
      assign oor_d = 1'b0;
    end
  endgenerate

  assign req_ready_o = (st_q == ST_IDLE);
  assign accept      = req_valid_i && req_ready_o;
  assign full_be     = &be_q;
  assign in_wait     = (st_q == ST_WAIT);
  assign rsp_valid_o = (st_q == ST_RESP);
  assign rsp_rdata_o = rdata_q;
  assign rsp_err_o   = err_q;
  assign rsp_ce_o    = ce_q;
  assign mem_addr_o  = addr_q[WORD_LSB +: MEM_AW];

  assign enc_in = (st_q == ST_WB) ? merge_q : wdata_q;
  ecc_enc u_enc (.data_i(enc_in), .word_o(enc_word));
  ecc_dec u_dec (.word_i(mem_rdata_i), .data_o(dec_data), .syn_o(dec_syn),
                 .ce_o(dec_ce), .ue_o(dec_ue));

  always_comb begin
    for (int b = 0; b < NB; b++)
      merged[8*b +: 8] = be_q[b] ? wdata_q[8*b +: 8] : dec_data[8*b +: 8];
  end

  // memory strobes
  always_comb begin
    mem_req_o   = 1'b0;
    mem_we_o    = 1'b0;
    mem_be_o    = '0;
    mem_wdata_o = '0;
    case (st_q)
      ST_EXEC: if (!oor_q) begin
        mem_req_o = 1'b1;
        if (wr_q && !ecc_q) begin
          mem_we_o    = 1'b1;
          mem_be_o    = {1'b0, be_q};
          mem_wdata_o = {{CW{1'b0}}, wdata_q};
        end else if (wr_q && full_be) begin
          mem_we_o    = 1'b1;
          mem_be_o    = '1;
          mem_wdata_o = enc_word;
        end
      end
      ST_WB: begin
        mem_req_o   = 1'b1;
        mem_we_o    = 1'b1;
        mem_be_o    = '1;
        mem_wdata_o = enc_word;
      end
      default: ;
    endcase
  end

  always_comb begin
    st_d = st_q;
    case (st_q)
      ST_IDLE: if (accept) st_d = ST_EXEC;
      ST_EXEC: st_d = (oor_q || (wr_q && (!ecc_q || full_be))) ? ST_RESP : ST_WAIT;
      ST_WAIT: begin
        if (wr_q)                                   st_d = dec_ue ? ST_RESP : ST_WB;
        else if (ecc_q && dec_ce && corr_q && scrub_q) st_d = ST_WB;
        else                                        st_d = ST_RESP;
      end
      ST_WB:   st_d = ST_RESP;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      wr_q    <= 1'b0;
      oor_q   <= 1'b0;
      ecc_q   <= 1'b0;
      corr_q  <= 1'b0;
      scrub_q <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
      be_q    <= '0;
      merge_q <= '0;
      rdata_q <= '0;
      err_q   <= 1'b0;
      ce_q    <= 1'b0;
    end else begin
      st_q <= st_d;
      if (accept) begin
        wr_q    <= req_write_i;
        oor_q   <= oor_d;
        ecc_q   <= cfg_ecc_en_i;
        corr_q  <= cfg_corr_en_i;
        scrub_q <= cfg_scrub_en_i;
        addr_q  <= req_addr_i[DEC_AW-1:0];
        wdata_q <= req_wdata_i;
        be_q    <= req_be_i;
        rdata_q <= '0;
        err_q   <= 1'b0;
        ce_q    <= 1'b0;
      end
      if (st_q == ST_EXEC && oor_q) err_q <= 1'b1;
      if (in_wait) begin
        if (ecc_q) begin
          err_q <= dec_ue;
          ce_q  <= dec_ce;
        end
        if (wr_q) merge_q <= merged;
        else begin
          merge_q <= dec_data;
          rdata_q <= (ecc_q && corr_q) ? dec_data : mem_rdata_i[DW-1:0];
        end
      end
    end
  end

  // capture slots: 0 = correctable, 1 = uncorrectable
  logic [NSLOT-1:0]  slot_ev, slot_vld;
  logic [DEC_AW-1:0] slot_addr [NSLOT];
  logic [CW-1:0]     slot_syn  [NSLOT];
  logic [CNT_W-1:0]  slot_cnt  [NSLOT];

  assign slot_ev[0] = in_wait && ecc_q && dec_ce;
  assign slot_ev[1] = in_wait && ecc_q && dec_ue;

  generate
    for (genvar g = 0; g < NSLOT; g++) begin : g_slot
      ecc_log_slot #(.AW(DEC_AW), .CNT_W(CNT_W)) u_slot (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .clr_i  (log_clr_i),
        .ev_i   (slot_ev[g]),
        .addr_i (addr_q),
        .syn_i  (dec_syn),
        .vld_o  (slot_vld[g]),
        .addr_o (slot_addr[g]),
        .syn_o  (slot_syn[g]),
        .cnt_o  (slot_cnt[g])
      );
    end
  endgenerate

  assign ce_vld_o  = slot_vld[0];
  assign ce_addr_o = slot_addr[0];
  assign ce_syn_o  = slot_syn[0];
  assign ce_cnt_o  = slot_cnt[0];
  assign ue_vld_o  = slot_vld[1];
  assign ue_addr_o = slot_addr[1];
  assign ue_syn_o  = slot_syn[1];
  assign ue_cnt_o  = slot_cnt[1];

  a_r11_rsp_to_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |=> req_ready_o);
  a_r11_single_flight: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept |=> !req_ready_o);
  a_r10_oor_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_EXEC && oor_q) |-> !mem_req_o);
  a_r9_no_check_lane: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_we_o && !ecc_q) |-> !mem_be_o[NB]);
  a_r1_all_lanes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_we_o && ecc_q) |-> (&mem_be_o));
  a_r2_even_word: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_we_o && ecc_q) |-> (^mem_wdata_o == 1'b0));
  a_r8_abort_merge: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_wait && wr_q && dec_ue) |=> !mem_req_o);
  a_r5_no_ue_scrub: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_wait && !wr_q && dec_ue) |=> !mem_we_o);
endmodule

// File: tb/ecc_rmw_scrubber_bench.sv
`timescale 1ns/1ps
module ecc_rmw_scrubber_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic        ecc_en = 1'b1, corr_en = 1'b1, scrub_en = 1'b0;
  logic        req_valid = 1'b0, req_ready, req_write = 1'b0;
  logic [39:0] req_addr = '0;
  logic [63:0] req_wdata = '0;
  logic [7:0]  req_be = '0;
  logic        rsp_valid, rsp_err, rsp_ce;
  logic [63:0] rsp_rdata;
  logic        mem_req, mem_we;
  logic [28:0] mem_addr;
  logic [8:0]  mem_be;
  logic [71:0] mem_wdata, mem_rdata;
  logic        log_clr = 1'b0;
  logic        ce_vld, ue_vld;
  logic [31:0] ce_addr, ue_addr;
  logic [7:0]  ce_syn, ue_syn;
  logic [15:0] ce_cnt, ue_cnt;

  ecc_rmw_scrubber u_ecc_rmw_scrubber (
    .clk_i(clk), .rst_ni(rst_n),
    .cfg_ecc_en_i(ecc_en), .cfg_corr_en_i(corr_en), .cfg_scrub_en_i(scrub_en),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_write_i(req_write),
    .req_addr_i(req_addr), .req_wdata_i(req_wdata), .req_be_i(req_be),
    .rsp_valid_o(rsp_valid), .rsp_rdata_o(rsp_rdata), .rsp_err_o(rsp_err), .rsp_ce_o(rsp_ce),
    .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr), .mem_be_o(mem_be),
    .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata),
    .log_clr_i(log_clr),
    .ce_vld_o(ce_vld), .ce_addr_o(ce_addr), .ce_syn_o(ce_syn), .ce_cnt_o(ce_cnt),
    .ue_vld_o(ue_vld), .ue_addr_o(ue_addr), .ue_syn_o(ue_syn), .ue_cnt_o(ue_cnt)
  );

  // memory model, one cycle read latency
  logic [71:0] mem [256];
  int wr_cnt = 0, acc_cnt = 0;
  always @(posedge clk) begin
    if (mem_req) begin
      acc_cnt <= acc_cnt + 1;
      if (mem_we) begin
        wr_cnt <= wr_cnt + 1;
        for (int l = 0; l < 9; l++)
          if (mem_be[l]) mem[mem_addr[7:0]][8*l +: 8] <= mem_wdata[8*l +: 8];
      end else mem_rdata <= mem[mem_addr[7:0]];
    end
  end

  int total = 0, bad = 0;
  bit done = 0;
  logic [63:0] g_data;
  logic        g_err, g_ce;
  int          g_wr, g_acc;

  task automatic chk(input string req, input logic [71:0] act, input logic [71:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic xfer(input logic wr, input logic [39:0] a, input logic [63:0] d, input logic [7:0] be);
    int w0, a0, guard;
    @(negedge clk);
    w0 = wr_cnt; a0 = acc_cnt;
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d; req_be = be;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    guard = 0;
    while (!rsp_valid && guard < 50) begin @(negedge clk); guard++; end
    g_data = rsp_rdata; g_err = rsp_err; g_ce = rsp_ce;
    g_wr = wr_cnt - w0; g_acc = acc_cnt - a0;
  endtask

  task automatic clear_log();
    @(negedge clk); log_clr = 1'b1;
    @(negedge clk); log_clr = 1'b0;
  endtask

  // {word index, data, byte enables}
  localparam logic [79:0] VEC [6] = '{
    {8'd3, 64'h0123_4567_89AB_CDEF, 8'hFF},
    {8'd3, 64'hFFFF_FFFF_FFFF_FFFF, 8'h0F},
    {8'd7, 64'hA5A5_A5A5_A5A5_A5A5, 8'h81},
    {8'd7, 64'h5A5A_5A5A_5A5A_5A5A, 8'hFF},
    {8'd9, 64'hDEAD_BEEF_0000_1111, 8'h3C},
    {8'd3, 64'h0000_0000_0000_0000, 8'hF0}
  };

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [63:0] shadow [256];
    logic [71:0] gold;
    for (int i = 0; i < 256; i++) begin mem[i] = '0; shadow[i] = '0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R11 reset ready", req_ready, 1);
    chk("R11 reset rsp", rsp_valid, 0);
    chk("R12 reset log", {ce_vld, ue_vld, ce_cnt, ue_cnt}, 0);

    // R1 R2 R7: vector walk with ECC on
    foreach (VEC[v]) begin
      logic [7:0]  ix;
      logic [63:0] d;
      logic [7:0]  be;
      {ix, d, be} = VEC[v];
      for (int b = 0; b < 8; b++) if (be[b]) shadow[ix][8*b +: 8] = d[8*b +: 8];
      xfer(1, {29'd0, ix, 3'd0}, d, be);
      chk("R1 R7 write err", g_err, 0);
      chk("R1 R7 one write", g_wr, 1);
      chk("R2 parity even", ^mem[ix], 0);
      chk("R2 data field", mem[ix][63:0], shadow[ix]);
      xfer(0, {29'd0, ix, 3'd0}, 0, 0);
      chk("R1 R7 readback", g_data, shadow[ix]);
      chk("R1 clean flags", {g_err, g_ce}, 0);
    end

    // R3: data bit error corrected, no scrub
    xfer(1, 40'd20 << 3, 64'hCAFE_F00D_1234_5678, 8'hFF);
    gold = mem[20];
    mem[20][5] = ~mem[20][5];
    xfer(0, 40'd20 << 3, 0, 0);
    chk("R3 corrected data", g_data, 64'hCAFE_F00D_1234_5678);
    chk("R3 flags", {g_err, g_ce}, 2'b01);
    chk("R3 no writeback", g_wr, 0);
    chk("R12 ce addr", ce_addr, 32'd160);
    chk("R12 ce syn odd", ce_syn[7], 1);

    // R12: check bit and parity bit syndromes
    clear_log();
    chk("R12 cleared", {ce_vld, ce_cnt}, 0);
    xfer(1, 40'd21 << 3, 64'h1111_2222_3333_4444, 8'hFF);
    mem[21][66] = ~mem[21][66];
    xfer(0, 40'd21 << 3, 0, 0);
    chk("R3 check bit err", {g_data, g_ce}, {64'h1111_2222_3333_4444, 1'b1});
    chk("R12 syn check bit 2", ce_syn, 8'h84);
    clear_log();
    mem[21][66] = ~mem[21][66];
    mem[21][71] = ~mem[21][71];
    xfer(0, 40'd21 << 3, 0, 0);
    chk("R12 syn parity bit", ce_syn, 8'h80);

    // R12: first capture held, counter counts
    clear_log();
    xfer(1, 40'd30 << 3, 64'h3030, 8'hFF);
    xfer(1, 40'd31 << 3, 64'h3131, 8'hFF);
    mem[30][12] = ~mem[30][12];
    mem[31][50] = ~mem[31][50];
    xfer(0, 40'd30 << 3, 0, 0);
    xfer(0, 40'd31 << 3, 0, 0);
    chk("R12 first addr held", ce_addr, 32'd240);
    chk("R12 count", ce_cnt, 2);

    // R4: correction off
    corr_en = 1'b0;
    xfer(1, 40'd22 << 3, 64'h0F0F_0F0F_0F0F_0F0F, 8'hFF);
    mem[22][10] = ~mem[22][10];
    xfer(0, 40'd22 << 3, 0, 0);
    chk("R4 raw data", g_data, 64'h0F0F_0F0F_0F0F_0F0F ^ (64'd1 << 10));
    chk("R4 ce reported", {g_err, g_ce}, 2'b01);
    corr_en = 1'b1;

    // R5: double error
    xfer(1, 40'd23 << 3, 64'h7777_8888_9999_AAAA, 8'hFF);
    mem[23][1] = ~mem[23][1];
    mem[23][40] = ~mem[23][40];
    scrub_en = 1'b1;
    xfer(0, 40'd23 << 3, 0, 0);
    chk("R5 flags", {g_err, g_ce}, 2'b10);
    chk("R5 no write", g_wr, 0);
    chk("R5 ue log", {ue_vld, ue_addr, ue_syn[7]}, {1'b1, 32'd184, 1'b0});

    // R6: scrub restores codeword
    xfer(1, 40'd24 << 3, 64'hBEEF_0001_BEEF_0002, 8'hFF);
    gold = mem[24];
    mem[24][33] = ~mem[24][33];
    xfer(0, 40'd24 << 3, 0, 0);
    chk("R6 data", g_data, 64'hBEEF_0001_BEEF_0002);
    chk("R6 one writeback", g_wr, 1);
    chk("R6 memory restored", mem[24], gold);
    scrub_en = 1'b0;

    // R7: merge over a corrected word
    xfer(1, 40'd25 << 3, 64'h1234_5678_9ABC_DEF0, 8'hFF);
    mem[25][2] = ~mem[25][2];
    xfer(1, 40'd25 << 3, 64'hAAAA_BBBB_CCCC_DDDD, 8'hF0);
    chk("R7 merge write", g_wr, 1);
    chk("R7 merged data", mem[25][63:0], 64'hAAAA_BBBB_9ABC_DEF0);
    xfer(0, 40'd25 << 3, 0, 0);
    chk("R7 clean after merge", {g_err, g_ce}, 0);

    // R8: merge aborted on uncorrectable word
    xfer(1, 40'd26 << 3, 64'h6666, 8'hFF);
    mem[26][3] = ~mem[26][3];
    mem[26][9] = ~mem[26][9];
    gold = mem[26];
    xfer(1, 40'd26 << 3, 64'hFFFF, 8'h01);
    chk("R8 err", g_err, 1);
    chk("R8 no write", g_wr, 0);
    chk("R8 memory kept", mem[26], gold);

    // R9: ECC off
    ecc_en = 1'b0;
    mem[40] = {8'hAB, 64'd0};
    xfer(1, 40'd40 << 3, 64'h0102_0304_0506_0708, 8'hFF);
    chk("R9 check lane untouched", mem[40], {8'hAB, 64'h0102_0304_0506_0708});
    xfer(1, 40'd40 << 3, 64'hFFFF_FFFF_FFFF_FF99, 8'h01);
    chk("R9 byte lane", mem[40][63:0], 64'h0102_0304_0506_0799);
    xfer(0, 40'd40 << 3, 0, 0);
    chk("R9 raw read", {g_data, g_err, g_ce}, {64'h0102_0304_0506_0799, 2'b00});
    ecc_en = 1'b1;

    // R10: address out of range
    clear_log();
    xfer(0, 40'h01_0000_0100, 0, 0);
    chk("R10 err", g_err, 1);
    chk("R10 no access", g_acc, 0);
    chk("R10 not logged", {ce_vld, ue_vld}, 0);

    // R11: one-cycle response pulse
    xfer(0, 40'd3 << 3, 0, 0);
    @(negedge clk);
    chk("R11 pulse width", {rsp_valid, req_ready}, 2'b01);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule